// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block is the front end of a programmable device's configuration controller. It decides when configuration memory must be wiped, wipes it, waits on the shared open-drain INIT line, and then captures the three mode pins. Once the mode is known, it turns on the configuration clock generator and the JTAG configuration path. After that it hands the INIT line over to the downstream bitstream loader for CRC error signalling.

A restart comes from any of three sources: a power-on indication, a qualified low pulse on the asynchronous active-low program pin, or a JTAG program strobe. Every restart passes through a one-cycle hold state. It then enters a clearing phase that runs one frame per clock for a parameterised number of frames, with INIT pulled low throughout. When clearing ends, INIT is released. An external agent may keep INIT low to stall configuration, but only until the mode has been captured. After capture, INIT is only an error output.

Top module: `cfg_init_seq`

## Requirements
- R1: A low level on `prog_n_i` shorter than `MIN_PULSE` clock cycles is ignored. A low level lasting `MIN_PULSE` cycles or more restarts the sequence, so `init_done_o` falls within `MIN_PULSE`+4 cycles of the start of the pulse.
- R2: While `prog_n_i` stays low after qualifying, `init_drive_o` stays 1 and both `init_done_o` and `jtag_en_o` stay 0.
- R3: After a restart is released, `init_drive_o` is 1 for exactly `FRAMES`+1 cycles: one hold cycle followed by `FRAMES` clearing cycles. It is then 0.
- R4: After clearing, while the INIT line reads low, `init_done_o` stays 0. It becomes 1 one cycle after the line reads high.
- R5: `mode_o` carries the mode pins as they were in the cycle the INIT line was first seen high. The bit order is the same, with `mode_o[2]` from `mode_pins_i[2]`.
- R6: Once `init_done_o` is 1, pulling INIT low or changing the mode pins has no effect on `init_done_o` or `mode_o`.
- R7: A pulse on `crc_err_i` while done sets `init_drive_o` to 1 until the next restart, and `init_done_o` stays 1. A pulse on `crc_err_i` before done is ignored.
- R8: `cclk_en_o` is 1 only while done and only for modes 000 and 011.
- R9: `width_o` is 1 for modes 011 and 110 and 2 for mode 001. It is 0 for all other codes and whenever not done.
- R10: `jtag_en_o` equals done. `jtag_prog_i` restarts the sequence only while done and is ignored otherwise.
- R11: While `por_i` is 1, the block holds as in R2. Clearing follows its release as in R3.
- R12: During reset, `init_drive_o` is 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on restart request, active high |
| prog_n_i | input | 1 | Asynchronous program request, active low |
| jtag_prog_i | input | 1 | JTAG program strobe |
| init_in_i | input | 1 | Sensed level of the INIT line |
| crc_err_i | input | 1 | CRC error pulse from the loader |
| mode_pins_i | input | 3 | Mode pins |
| init_drive_o | output | 1 | Enable to pull INIT low |
| init_done_o | output | 1 | Mode captured, initialization complete |
| mode_o | output | 3 | Captured mode |
| cclk_en_o | output | 1 | Master configuration clock enable |
| width_o | output | 2 | Data width code: 0 = 1-bit, 1 = 8-bit, 2 = 32-bit |
| jtag_en_o | output | 1 | JTAG configuration path usable |

## Verification
Each result has a fixed latency:
- A JTAG strobe or an INIT rising level shows on the outputs one cycle later.
- A CRC pulse reaches `init_drive_o` one cycle later.
- A program pulse needs two synchroniser cycles plus `MIN_PULSE` counting cycles plus one state cycle.
- The clearing window lasts exactly `FRAMES`+1 cycles.

The bench drives inputs and samples outputs on the falling clock edge. It counts falling edges from the stimulus and compares each result at the cycle where it is due. The clearing window is measured as an exact run length of `init_drive_o`. Ignored stimuli are judged by whether `init_done_o` and `init_drive_o` changed in the cycles where the effect would have appeared.

// File: rtl/cfg_init_pkg.sv
package cfg_init_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  // modes whose configuration clock is generated on chip
  function automatic logic mode_is_master(input logic [2:0] m);
    return (m == 3'b000) || (m == 3'b011);
  endfunction

  // 0 = 1-bit, 1 = 8-bit, 2 = 32-bit
  function automatic logic [1:0] mode_width(input logic [2:0] m);
    case (m)
      3'b011, 3'b110: return 2'd1;
      3'b001:         return 2'd2;
      default:        return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/cfg_prog_filter.sv
module cfg_prog_filter #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n_i,
  output logic hold_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_PULSE);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] low_cnt_q, low_cnt_d;

  always_comb begin
    low_cnt_d = low_cnt_q;
    if (sync2_q)
      low_cnt_d = '0;
    else if (low_cnt_q != LIM)
      low_cnt_d = low_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q   <= 1'b1;
      sync2_q   <= 1'b1;
      low_cnt_q <= '0;
    end else begin
      sync1_q   <= prog_n_i;
      sync2_q   <= sync1_q;
      low_cnt_q <= low_cnt_d;
    end
  end

  assign hold_o = (low_cnt_q == LIM);

  // R1: the hold request only rises after the synchronised pin was low
  a_r1_hold_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(!sync2_q));

endmodule

// File: rtl/cfg_frame_clear.sv
module cfg_frame_clear #(
  parameter int FRAMES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam logic [FW-1:0] TOP = FW'(FRAMES - 1);

  logic [FW-1:0] frame_q, frame_d;

  always_comb begin
    frame_d = frame_q;
    if (!run_i || frame_q == TOP)
      frame_d = '0;
    else
      frame_d = frame_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end

  assign last_o = run_i && (frame_q == TOP);

  // R3: the frame index never leaves its range
  a_r3_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q <= TOP);

endmodule

// File: rtl/cfg_init_seq.sv
module cfg_init_seq
  import cfg_init_pkg::*;
#(
  parameter int FRAMES    = 40,
  parameter int MIN_PULSE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       prog_n_i,
  input  logic       jtag_prog_i,
  input  logic       init_in_i,
  input  logic       crc_err_i,
  input  logic [2:0] mode_pins_i,
  output logic       init_drive_o,
  output logic       init_done_o,
  output logic [2:0] mode_o,
  output logic       cclk_en_o,
  output logic [1:0] width_o,
  output logic       jtag_en_o
);

  seq_state_t state_q, state_d;
  logic [2:0] mode_q, mode_d;
  logic       crc_q, crc_d;
  logic       prog_hold, clr_last, restart, done;

  cfg_prog_filter #(.MIN_PULSE(MIN_PULSE)) u_prog (
    .clk(clk), .rst_n(rst_n), .prog_n_i(prog_n_i), .hold_o(prog_hold));

  cfg_frame_clear #(.FRAMES(FRAMES)) u_clear (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_CLEAR), .last_o(clr_last));

  assign done    = (state_q == ST_DONE);
  assign restart = por_i || prog_hold || (jtag_prog_i && done);

  always_comb begin
    state_d = state_q;
    if (restart) state_d = ST_HOLD;
    else begin
      case (state_q)
        ST_HOLD:  state_d = ST_CLEAR;
        ST_CLEAR: if (clr_last)  state_d = ST_WAIT;
        ST_WAIT:  if (init_in_i) state_d = ST_DONE;
        default:  state_d = ST_DONE;
      endcase
    end
  end

  always_comb begin
    mode_d = mode_q;
    crc_d  = crc_q;
    if (state_q == ST_HOLD) begin
      mode_d = '0;
      crc_d  = 1'b0;
    end else if (state_q == ST_WAIT && init_in_i && !restart) begin
      mode_d = mode_pins_i;
    end else if (done && crc_err_i) begin
      crc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      mode_q  <= '0;
      crc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      crc_q   <= crc_d;
    end
  end

  assign init_drive_o = (state_q == ST_HOLD) || (state_q == ST_CLEAR) || crc_q;
  assign init_done_o  = done;
  assign mode_o       = mode_q;
  assign cclk_en_o    = done && mode_is_master(mode_q);
  assign width_o      = done ? mode_width(mode_q) : 2'd0;
  assign jtag_en_o    = done;

  // R2: a qualified program request always lands in the hold state
  a_r2_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
    prog_hold |=> (state_q == ST_HOLD));

  // R6: the captured mode does not move while done
  a_r6_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> $stable(mode_q));

  // R10: a JTAG strobe outside done never causes a restart
  a_r10_jtag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (jtag_prog_i && state_q == ST_WAIT && !por_i && !prog_hold) |=> (state_q != ST_HOLD));

  // R3: clearing only ends toward the wait state
  a_r3_clear_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLEAR && !restart) |=> (state_q == ST_CLEAR || state_q == ST_WAIT));

  // R8: the clock generator only runs once initialization is complete
  a_r8_cclk_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_en_o |-> init_done_o);

endmodule

// File: tb/test_cfg_init_seq.sv
module test_cfg_init_seq;
  localparam int FRAMES    = 40;
  localparam int MIN_PULSE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 1'b0, prog_n = 1'b1, jtag = 1'b0, crc = 1'b0, ext_low = 1'b0;
  logic [2:0] pins = 3'b000;
  logic drive, done, cclk, jen, init_line;
  logic [2:0] mode;
  logic [1:0] width;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign init_line = ~drive & ~ext_low;

  cfg_init_seq #(.FRAMES(FRAMES), .MIN_PULSE(MIN_PULSE)) i_cfg_init_seq (
    .clk(clk), .rst_n(rst_n), .por_i(por), .prog_n_i(prog_n), .jtag_prog_i(jtag),
    .init_in_i(init_line), .crc_err_i(crc), .mode_pins_i(pins),
    .init_drive_o(drive), .init_done_o(done), .mode_o(mode), .cclk_en_o(cclk),
    .width_o(width), .jtag_en_o(jen));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic count_drive(output int n);
    n = 0;
    while (drive && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic jtag_restart();
    @(negedge clk); jtag = 1'b1;
    @(negedge clk); jtag = 1'b0;
  endtask

  function automatic int exp_width(input logic [2:0] m);
    if (m == 3'b011 || m == 3'b110) return 1;
    if (m == 3'b001) return 2;
    return 0;
  endfunction

  task automatic t_reset();
    int n;
    @(negedge clk);
    chk("R12 drive", drive, 1);
    chk("R12 done", done, 0);
    chk("R12 mode", mode, 0);
    chk("R12 cclk", cclk, 0);
    chk("R12 jtag_en", jen, 0);
    pins = 3'b011;
    rst_n = 1'b1;
    count_drive(n);
    chk("R3 power-up clear length", n, FRAMES + 1);
    chk("R4 not done in wait cycle", done, 0);
    @(negedge clk);
    chk("R4 done after line high", done, 1);
    chk("R5 mode captured", mode, 3);
  endtask

  task automatic t_modes();
    int n;
    for (int m = 0; m < 8; m++) begin
      pins = 3'(m);
      jtag_restart();
      chk("R10 jtag restart in done", done, 0);
      count_drive(n);
      chk("R3 clear length after jtag", n, FRAMES + 1);
      wait_done(n);
      chk("R5 mode", mode, m);
      chk("R8 cclk", cclk, (m == 0 || m == 3) ? 1 : 0);
      chk("R9 width", width, exp_width(3'(m)));
      chk("R10 jtag_en", jen, 1);
    end
  endtask

  task automatic t_stall();
    int n;
    pins = 3'b110;
    ext_low = 1'b1;
    jtag_restart();
    chk("R8 cclk off while not done", cclk, 0);
    chk("R9 width zero while not done", width, 0);
    repeat (FRAMES + 20) @(negedge clk);
    chk("R4 stalled not done", done, 0);
    chk("R4 released drive", drive, 0);
    jtag = 1'b1;
    crc = 1'b1;
    @(negedge clk);
    jtag = 1'b0;
    crc = 1'b0;
    chk("R10 jtag ignored in wait", drive, 0);
    ext_low = 1'b0;
    @(negedge clk);
    chk("R4 done one cycle after release", done, 1);
    chk("R5 mode after stall", mode, 6);
    chk("R7 earlier crc ignored", drive, 0);
  endtask

  task automatic t_late_low();
    ext_low = 1'b1;
    pins = 3'b001;
    repeat (20) @(negedge clk);
    chk("R6 done kept", done, 1);
    chk("R6 mode kept", mode, 6);
    ext_low = 1'b0;
  endtask

  task automatic t_crc();
    int n;
    @(negedge clk); crc = 1'b1;
    @(negedge clk); crc = 1'b0;
    chk("R7 crc drives init", drive, 1);
    chk("R7 done kept", done, 1);
    repeat (5) @(negedge clk);
    chk("R7 crc latched", drive, 1);
    pins = 3'b000;
    jtag_restart();
    wait_done(n);
    chk("R7 crc cleared by restart", drive, 0);
  endtask

  task automatic t_prog();
    int n;
    bit saw_low;
    @(negedge clk); prog_n = 1'b0;
    repeat (MIN_PULSE - 1) @(negedge clk);
    prog_n = 1'b1;
    saw_low = 0;
    repeat (MIN_PULSE + 6) begin @(negedge clk); if (!done) saw_low = 1; end
    chk("R1 short pulse ignored", saw_low, 0);
    prog_n = 1'b0;
    repeat (MIN_PULSE) @(negedge clk);
    prog_n = 1'b1;
    saw_low = 0;
    repeat (4) begin @(negedge clk); if (!done) saw_low = 1; end
    chk("R1 minimum pulse restarts", saw_low, 1);
    wait_done(n);
    chk("R1 done again", done, 1);
    prog_n = 1'b0;
    repeat (60) @(negedge clk);
    chk("R2 drive held", drive, 1);
    chk("R2 not done", done, 0);
    chk("R2 jtag off", jen, 0);
    prog_n = 1'b1;
    wait_done(n);
    chk("R2 recovers", done, 1);
  endtask

  task automatic t_por();
    int n;
    @(negedge clk); por = 1'b1;
    repeat (10) @(negedge clk);
    chk("R11 drive held", drive, 1);
    chk("R11 not done", done, 0);
    por = 1'b0;
    @(negedge clk);
    count_drive(n);
    chk("R11 clear length", n, FRAMES);
    @(negedge clk);
    chk("R11 done", done, 1);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_stall();
    t_late_low();
    t_crc();
    t_prog();
    t_por();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule